// File: doc/BRIEF.md
# Vectored interrupt entry sequencer

This block carries out the interrupt entry of a 16-bit real-mode processor once the core signals that an instruction has retired. When a request is pending at such a boundary and may be taken, the sequencer saves the return state on the stack through a byte-wide memory port. It then fetches the handler address from the vector table at the bottom of physical memory, and hands the core its new flags, code segment, instruction pointer and stack pointer.

Two vectors cannot be masked and always enter. Every other vector needs the interrupt-enable flag. A segment-override prefix that is still in force holds entry off until a later boundary. A repeat or override prefix that the interrupted instruction had already consumed is re-run on return: the sequencer saves an instruction pointer one byte back. Memory accesses use a request/acknowledge handshake, one byte per acknowledge. The address stays stable until the acknowledge arrives.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is started only in a cycle where `boundary` and `irq_pend` are both 1 and the block is neither busy nor pulsing `done`. Without `boundary`, a pending request starts nothing.
- R2: Vectors 0 and 2 are taken whatever the flags say. Any other vector is taken only when `flags_in` bit 9 (interrupt enable) is 1. Otherwise nothing happens.
- R3: While `segovr_act` is 1 at a boundary, entry is not started. A later boundary without it takes the request.
- R4: Three words are pushed: FLAGS first, then CS, then IP. Before each word SP drops by 2, modulo 2^16. The word goes to physical address (SS*16 + SP) mod 2^20, low byte first. The high byte goes to SS*16 + ((SP+1) mod 2^16), also wrapped to 20 bits. All six writes come before any read.
- R5: The pushed FLAGS is the value of `flags_in`. `flags_out` equals that value with bit 9 (interrupt enable) and bit 8 (trap) cleared.
- R6: When `prefix_pend` is 1 at acceptance, the saved IP is `ip_in` - 1 modulo 2^16. Otherwise it is `ip_in`.
- R7: The new IP is read little-endian from physical bytes vec*4 and vec*4+1, and the new CS from vec*4+2 and vec*4+3, in that order. They appear on `ip_out` and `cs_out`.
- R8: `sp_out` equals `sp_in` - 6 modulo 2^16 after entry.
- R9: `done` is high for exactly one cycle per entry. Boundaries seen while busy are ignored and cause no extra memory traffic.
- R10: After reset `busy`, `done` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boundary | input | 1 | Instruction just completed |
| irq_pend | input | 1 | An interrupt request is pending |
| irq_vec | input | 8 | Pending vector number |
| prefix_pend | input | 1 | Override or repeat prefix already consumed |
| segovr_act | input | 1 | Segment override still in force |
| flags_in | input | 16 | Current FLAGS |
| cs_in | input | 16 | Current CS |
| ip_in | input | 16 | Current IP |
| sp_in | input | 16 | Current SP |
| ss_in | input | 16 | Current SS |
| mem_req | output | 1 | Byte access requested |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with acknowledge |
| mem_ack | input | 1 | Access completed |
| busy | output | 1 | Entry in progress |
| done | output | 1 | One-cycle completion pulse; clears the request |
| flags_out | output | 16 | FLAGS with IF and TF cleared |
| cs_out | output | 16 | Handler CS |
| ip_out | output | 16 | Handler IP |
| sp_out | output | 16 | Stack pointer after the pushes |

## Verification
The bench builds the block with its default parameters: a 20-bit physical address, a 4-bit segment shift and an 8-bit vector. These values bring the 1 MiB wrap of a stack near the top of memory within reach, as well as the 16-bit wrap of SP and of a decremented IP of zero. The highest vector, whose table entry starts at byte 0x3FC, is also reachable. The memory model inserts stalls on some runs, so the address and data must hold through a wait.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4,
  parameter int VEC_W     = 8,
  parameter int IF_BIT    = 9,
  parameter int TF_BIT    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              irq_pend,
  input  logic [VEC_W-1:0]  irq_vec,
  input  logic              prefix_pend,
  input  logic              segovr_act,
  input  logic [15:0]       flags_in,
  input  logic [15:0]       cs_in,
  input  logic [15:0]       ip_in,
  input  logic [15:0]       sp_in,
  input  logic [15:0]       ss_in,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  output logic              busy,
  output logic              done,
  output logic [15:0]       flags_out,
  output logic [15:0]       cs_out,
  output logic [15:0]       ip_out,
  output logic [15:0]       sp_out
);
  localparam int PUSH_BYTES = 6;
  localparam int LAST_STEP  = PUSH_BYTES + 3;
  localparam logic [15:0] CLR_MASK = ~((16'd1 << IF_BIT) | (16'd1 << TF_BIT));

  logic [3:0]       step;
  logic [VEC_W-1:0] vec_q;
  logic [15:0]      flags_q, cs_q, ip_q, sp_q, ss_q, nip_q, ncs_q;

  wire unmaskable = (irq_vec == VEC_W'(0)) || (irq_vec == VEC_W'(2));
  wire start = boundary && irq_pend && !busy && !done && !segovr_act &&
               (unmaskable || flags_in[IF_BIT]);

  wire        pushing  = step < 4'(PUSH_BYTES);
  wire [1:0]  wsel     = step[2:1];
  wire [15:0] push_sp  = sp_q - {13'd0, wsel, 1'b0} - 16'd2;
  wire [15:0] push_off = push_sp + {15'd0, step[0]};
  wire [ADDR_W-1:0] seg_base  = ADDR_W'(ss_q) << SEG_SHIFT;
  wire [ADDR_W-1:0] push_addr = seg_base + ADDR_W'(push_off);
  wire [3:0]        rd_idx    = step - 4'(PUSH_BYTES);
  wire [ADDR_W-1:0] rd_addr   = (ADDR_W'(vec_q) << 2) + ADDR_W'(rd_idx[1:0]);

  logic [15:0] push_word;
  always_comb begin
    case (wsel)
      2'd0:    push_word = flags_q;
      2'd1:    push_word = cs_q;
      default: push_word = ip_q;
    endcase
  end

  assign mem_req   = busy;
  assign mem_we    = busy && pushing;
  assign mem_addr  = pushing ? push_addr : rd_addr;
  assign mem_wdata = step[0] ? push_word[15:8] : push_word[7:0];

  assign flags_out = flags_q & CLR_MASK;
  assign cs_out    = ncs_q;
  assign ip_out    = nip_q;
  assign sp_out    = sp_q - 16'd6;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      step    <= '0;
      vec_q   <= '0;
      flags_q <= '0;
      cs_q    <= '0;
      ip_q    <= '0;
      sp_q    <= '0;
      ss_q    <= '0;
      nip_q   <= '0;
      ncs_q   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        step    <= '0;
        vec_q   <= irq_vec;
        flags_q <= flags_in;
        cs_q    <= cs_in;
        ip_q    <= ip_in - {15'd0, prefix_pend};
        sp_q    <= sp_in;
        ss_q    <= ss_in;
      end else if (busy && mem_ack) begin
        case (rd_idx)
          4'd0: nip_q[7:0]  <= mem_rdata;
          4'd1: nip_q[15:8] <= mem_rdata;
          4'd2: ncs_q[7:0]  <= mem_rdata;
          4'd3: ncs_q[15:8] <= mem_rdata;
          default: ;
        endcase
        if (step == 4'(LAST_STEP)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
        step <= step + 4'd1;
      end
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_req_only_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);
  p_seg_defer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && segovr_act && !busy) |=> !busy);
  p_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !busy && !flags_in[IF_BIT] && irq_vec != VEC_W'(0) &&
     irq_vec != VEC_W'(2)) |=> !busy);
  p_no_boundary_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!boundary && !busy) |=> !busy);
  p_hold_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  p_flags_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!flags_out[IF_BIT] && !flags_out[TF_BIT]));
endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic boundary = 0, irq_pend = 0, prefix_pend = 0, segovr_act = 0;
  logic [7:0] irq_vec = 0;
  logic [15:0] flags_in = 0, cs_in = 0, ip_in = 0, sp_in = 0, ss_in = 0;
  logic mem_req, mem_we, mem_ack = 0, busy, done;
  logic [19:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = 0;
  logic [15:0] flags_out, cs_out, ip_out, sp_out;

  irq_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .irq_pend(irq_pend),
    .irq_vec(irq_vec), .prefix_pend(prefix_pend), .segovr_act(segovr_act),
    .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in), .sp_in(sp_in),
    .ss_in(ss_in), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .busy(busy), .done(done), .flags_out(flags_out), .cs_out(cs_out),
    .ip_out(ip_out), .sp_out(sp_out));

  int total = 0, bad = 0, done_cnt = 0, wr_cnt = 0, rd_cnt = 0, cyc = 0;
  bit slow = 0;
  bit [7:0] mem [int];
  logic [27:0] exp_wr [$];
  logic [19:0] exp_rd [$];
  logic [63:0] exp_res [$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mem_ack) mem_ack = 0;
    else if (mem_req && !(slow && (cyc % 3 != 0))) begin
      mem_ack = 1;
      if (mem_we) begin
        wr_cnt++;
        mem[int'(mem_addr)] = mem_wdata;
        if (exp_wr.size() == 0) check("R9 unexpected write", {12'd0, mem_addr}, 32'hFFFFFFFF);
        else begin
          logic [27:0] e;
          e = exp_wr.pop_front();
          check("R4/R6 write", {4'd0, mem_addr, mem_wdata}, {4'd0, e});
        end
      end else begin
        rd_cnt++;
        mem_rdata = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
        if (exp_wr.size() != 0) check("R4 read before pushes done", exp_wr.size(), 0);
        if (exp_rd.size() == 0) check("R9 unexpected read", {12'd0, mem_addr}, 32'hFFFFFFFF);
        else check("R7 read address", {12'd0, mem_addr}, {12'd0, exp_rd.pop_front()});
      end
    end
  end

  always @(negedge clk) begin
    if (done) begin
      done_cnt++;
      if (exp_res.size() == 0) check("R9 extra done", done_cnt, 0);
      else begin
        logic [63:0] r;
        r = exp_res.pop_front();
        check("R5 flags_out", flags_out, r[63:48]);
        check("R7 cs_out", cs_out, r[47:32]);
        check("R7 ip_out", ip_out, r[31:16]);
        check("R8 sp_out", sp_out, r[15:0]);
      end
    end
  end

  task automatic set_vec(input int v, input logic [15:0] nip, input logic [15:0] ncs);
    mem[v*4] = nip[7:0]; mem[v*4+1] = nip[15:8];
    mem[v*4+2] = ncs[7:0]; mem[v*4+3] = ncs[15:8];
  endtask

  task automatic push_exp(input logic [15:0] ss, input logic [15:0] sp, input logic [15:0] w);
    logic [15:0] lo_off, hi_off;
    lo_off = sp;
    hi_off = sp + 16'd1;
    exp_wr.push_back({20'((int'(ss) << 4) + int'(lo_off)), w[7:0]});
    exp_wr.push_back({20'((int'(ss) << 4) + int'(hi_off)), w[15:8]});
  endtask

  task automatic fire(input logic [7:0] v, input logic [15:0] fl, input logic [15:0] cs,
                      input logic [15:0] ip, input logic [15:0] sp, input logic [15:0] ss,
                      input logic pref, input logic sovr, input logic bnd, input string tag);
    int d0, w0;
    bit take;
    logic [15:0] sip;
    d0 = done_cnt; w0 = wr_cnt;
    take = bnd && !sovr && (v == 0 || v == 2 || fl[9]);
    sip = ip - {15'd0, pref};
    if (take) begin
      push_exp(ss, sp - 16'd2, fl);
      push_exp(ss, sp - 16'd4, cs);
      push_exp(ss, sp - 16'd6, sip);
      for (int k = 0; k < 4; k++) exp_rd.push_back(20'(int'(v) * 4 + k));
      exp_res.push_back({fl & 16'hFCFF,
                         {mem[int'(v)*4+3], mem[int'(v)*4+2]},
                         {mem[int'(v)*4+1], mem[int'(v)*4]}, sp - 16'd6});
    end
    @(negedge clk);
    irq_vec = v; flags_in = fl; cs_in = cs; ip_in = ip; sp_in = sp; ss_in = ss;
    prefix_pend = pref; segovr_act = sovr; boundary = bnd; irq_pend = 1;
    @(negedge clk);
    boundary = 0;
    if (take) begin
      for (int k = 0; k < 400 && done_cnt == d0; k++) @(negedge clk);
      irq_pend = 0;
      check({tag, " done count"}, done_cnt - d0, 1);
      check({tag, " R4 all pushes"}, exp_wr.size() + exp_rd.size(), 0);
    end else begin
      repeat (30) @(negedge clk);
      irq_pend = 0;
      check({tag, " no entry busy"}, busy, 0);
      check({tag, " no entry done"}, done_cnt - d0, 0);
      check({tag, " no entry writes"}, wr_cnt - w0, 0);
    end
    segovr_act = 0; prefix_pend = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    set_vec(8'h21, 16'h1234, 16'hABCD);
    set_vec(0, 16'h0100, 16'hF000);
    set_vec(2, 16'hBEEF, 16'h0040);
    set_vec(5, 16'h5555, 16'h6666);
    set_vec(8'hFF, 16'hC3A5, 16'h9E01);
    set_vec(8'h10, 16'h0F0F, 16'hF0F0);
    repeat (3) @(negedge clk);
    check("R10 busy", busy, 0);
    check("R10 done", done, 0);
    check("R10 mem_req", mem_req, 0);
    rst_n = 1;
    @(negedge clk);

    fire(8'h21, 16'h0302, 16'h2000, 16'h0456, 16'h8000, 16'h3000, 0, 0, 1, "R2 maskable IF=1");
    fire(8'h02, 16'h0002, 16'h1111, 16'h2222, 16'h0100, 16'h0500, 0, 0, 1, "R2 vector 2 IF=0");
    fire(8'h00, 16'h0102, 16'h7777, 16'h8888, 16'h0200, 16'h0000, 0, 0, 1, "R2 vector 0 IF=0");
    fire(8'h05, 16'h0102, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 0, 0, 1, "R2 masked vector 5");
    fire(8'h21, 16'h0202, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 0, 0, 0, "R1 no boundary");
    fire(8'h21, 16'h0202, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 0, 1, 1, "R3 override defers");
    fire(8'h21, 16'h0202, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 0, 0, 1, "R3 retried later");
    fire(8'h10, 16'h0202, 16'h1000, 16'h2001, 16'h3000, 16'h4000, 1, 0, 1, "R6 prefix backs IP");
    fire(8'h10, 16'h0202, 16'h1000, 16'h0000, 16'h3000, 16'h4000, 1, 0, 1, "R6 IP wraps");
    slow = 1;
    fire(8'hFF, 16'hFFFF, 16'hCAFE, 16'hD00D, 16'h0002, 16'hFFFF, 0, 0, 1, "R4 SP and 1MiB wrap");
    fire(8'h00, 16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'hF123, 1, 0, 1, "R4 odd SP slow");
    slow = 0;

    begin
      int d0;
      d0 = done_cnt;
      exp_res.push_back({16'h0000 & 16'hFCFF, 16'hABCD, 16'h1234, 16'h5FFA});
      push_exp(16'h0800, 16'h5FFE, 16'h0200);
      push_exp(16'h0800, 16'h5FFC, 16'h0123);
      push_exp(16'h0800, 16'h5FFA, 16'h0456);
      for (int k = 0; k < 4; k++) exp_rd.push_back(20'(8'h21 * 4 + k));
      @(negedge clk);
      irq_vec = 8'h21; flags_in = 16'h0200; cs_in = 16'h0123; ip_in = 16'h0456;
      sp_in = 16'h6000; ss_in = 16'h0800; boundary = 1; irq_pend = 1;
      @(negedge clk);
      irq_vec = 8'h05; flags_in = 16'h0300; ip_in = 16'h9999;
      repeat (4) @(negedge clk);
      boundary = 0;
      @(negedge clk);
      boundary = 1;
      @(negedge clk);
      boundary = 0;
      for (int k = 0; k < 400 && done_cnt == d0; k++) @(negedge clk);
      irq_pend = 0;
      repeat (40) @(negedge clk);
      check("R9 one done while busy boundaries", done_cnt - d0, 1);
      check("R9 queues drained", exp_wr.size() + exp_rd.size() + exp_res.size(), 0);
    end
    summary();
  end
endmodule